// File: doc/BRIEF.md
# Coprocessor Access Permission Checker

This block stores the access rights for the coprocessor instruction space. It decides, in the same cycle that an instruction is presented, whether that instruction must be turned into an undefined-instruction trap. The coprocessor number is taken from a fixed field of the instruction word. Coprocessors below a parameterised count are checked, and the rest are always let through.

Two schemes are supported. In the normal scheme, each checked coprocessor owns a two-bit permission code in a control register, and the code's meaning can depend on whether the core runs in user mode. In the alternate scheme, selected by a mode input, the codes are ignored and a separate enable register gives one bit per checked coprocessor. Writes to the permission register are limited to the fields of coprocessors that exist. When a floating-point unit is present, only the fields of coprocessors 10 and 11 can be written, and every other bit reads as zero.

A separate flag reports traps caused by the reserved permission code, so that a surrounding core can count them as guest errors.

Top module: `cp_access_gate`

## Requirements
- R1: The coprocessor number is instruction bits [11:8]. No other instruction bit affects the result.
- R2: Coprocessors 14 and 15 never raise `trap` or `trap_reserved`.
- R3: In the normal scheme, permission code 0 (field bits [2n+1:2n] of the permission register for coprocessor n) raises `trap` in both modes.
- R4: In the normal scheme, code 1 raises `trap` only when `user_mode` is 1.
- R5: In the normal scheme, code 2 raises `trap` in both modes.
- R6: In the normal scheme, code 3 never raises `trap`.
- R7: A write to the permission register (`reg_sel`=0) stores `reg_wdata & 32'h00F00000` when `fpu_present` is 1, and stores 0 otherwise. The stored value reads back on `reg_rdata` in the cycle after the write, and all other bits read 0.
- R8: With `alt_mode`=1, the permission codes are ignored. A checked coprocessor n traps exactly when bit n of the enable register is 0. The enable register is written with `reg_sel`=1 from `reg_wdata[13:0]`, and bits [31:14] read 0.
- R9: After reset, both registers read 0, so every checked coprocessor traps.
- R10: `trap` and `trap_reserved` are combinational in the `insn_valid` cycle and are 0 whenever `insn_valid` is 0.
- R11: `trap_reserved` is 1 exactly when `trap` is caused by code 2 in the normal scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_present | input | 1 | Floating-point unit present; enables the writable permission fields |
| alt_mode | input | 1 | Selects the single-bit enable scheme |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = permission register, 1 = enable register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register chosen by `reg_sel` |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 32 | Instruction word |
| user_mode | input | 1 | 1 = user (unprivileged) mode |
| trap | output | 1 | Undefined-instruction trap request |
| trap_reserved | output | 1 | Trap caused by the reserved permission code |

## Verification
The bench builds the block with its default parameters: 14 checked coprocessors, a four-bit number field at bit 8, and the floating-point write mask. With these values the whole space can be covered. Every one of the 16 values of the writable fields is tried against all 16 coprocessor numbers in both privilege modes, so each of the four permission codes is reached on both coprocessors 10 and 11. Alternate mode is swept with several enable patterns, and the bench shows that the permission register has no effect there. Expected values come from arithmetic on the stored register images.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  localparam int CP_NUM_W = 4;
  localparam int CP_SPACE = 1 << CP_NUM_W;

  typedef logic [CP_NUM_W-1:0] cp_num_t;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_PRIV = 2'd1,
    PERM_RSVD = 2'd2,
    PERM_FULL = 2'd3
  } perm_code_e;

  // Coprocessor number field from an instruction word
  function automatic cp_num_t cp_num_of(input logic [31:0] insn, input int lsb);
    logic [31:0] sh;
    sh = insn >> lsb;
    return sh[CP_NUM_W-1:0];
  endfunction

  // Two-bit permission code of coprocessor n
  function automatic perm_code_e perm_field(input logic [31:0] r, input cp_num_t n);
    logic [31:0] sh;
    sh = r >> (2 * int'(n));
    return perm_code_e'(sh[1:0]);
  endfunction

  // Does a permission code deny access in the given mode
  function automatic logic perm_denies(input perm_code_e c, input logic user);
    case (c)
      PERM_NONE: return 1'b1;
      PERM_PRIV: return user;
      PERM_RSVD: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  // Writable-bit mask of the permission register
  function automatic logic [31:0] perm_wr_mask(input logic fpu, input logic [31:0] fp_mask);
    return fpu ? fp_mask : 32'h0;
  endfunction

endpackage

// File: rtl/cpg_perm_reg.sv
module cpg_perm_reg
  import cpg_pkg::*;
#(
  parameter logic [31:0] FP_MASK = 32'h00F0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        fpu_present,
  output logic [31:0] perm_q
);

  logic [31:0] wr_mask;
  logic [31:0] perm_d;

  assign wr_mask = perm_wr_mask(fpu_present, FP_MASK);
  assign perm_d  = wdata & wr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perm_q <= '0;
    else if (wr_en) perm_q <= perm_d;
  end

  // R7
  raz_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_q & ~FP_MASK) == 32'h0);

  // R9
  perm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> perm_q == 32'h0);

endmodule

// File: rtl/cpg_enable_reg.sv
module cpg_enable_reg #(
  parameter int NUM_CHECKED = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [NUM_CHECKED-1:0] wdata,
  output logic [NUM_CHECKED-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) en_q <= wdata;
  end

  // R9
  en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> en_q == '0);

endmodule

// File: rtl/cpg_decide.sv
module cpg_decide
  import cpg_pkg::*;
#(
  parameter int NUM_CHECKED  = 14,
  parameter int CP_FIELD_LSB = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   insn_valid,
  input  logic [31:0]            insn,
  input  logic                   user_mode,
  input  logic                   alt_mode,
  input  logic [31:0]            perm_q,
  input  logic [NUM_CHECKED-1:0] en_q,
  output logic                   trap,
  output logic                   trap_reserved,
  output cp_num_t                cp_num
);

  logic [CP_SPACE-1:0] deny_perm;
  logic [CP_SPACE-1:0] deny_alt;
  logic [CP_SPACE-1:0] rsvd_vec;
  logic [CP_SPACE-1:0] en_pad;
  logic                deny_sel;
  logic                rsvd_sel;

  assign cp_num = cp_num_of(insn, CP_FIELD_LSB);

  for (genvar i = 0; i < CP_SPACE; i++) begin : g_cp
    if (i < NUM_CHECKED) begin : g_checked
      perm_code_e code;
      assign code         = perm_code_e'(perm_q[2*i+1:2*i]);
      assign deny_perm[i] = perm_denies(code, user_mode);
      assign rsvd_vec[i]  = (code == PERM_RSVD);
      assign deny_alt[i]  = ~en_q[i];
      assign en_pad[i]    = en_q[i];
    end else begin : g_free
      assign deny_perm[i] = 1'b0;
      assign rsvd_vec[i]  = 1'b0;
      assign deny_alt[i]  = 1'b0;
      assign en_pad[i]    = 1'b1;
    end
  end

  assign deny_sel      = alt_mode ? deny_alt[cp_num] : deny_perm[cp_num];
  assign rsvd_sel      = ~alt_mode & rsvd_vec[cp_num];
  assign trap          = insn_valid & deny_sel;
  assign trap_reserved = insn_valid & rsvd_sel;

  // R6
  full_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !alt_mode && perm_field(perm_q, cp_num) == PERM_FULL) |-> !trap);

  // R3
  none_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !alt_mode && int'(cp_num) < NUM_CHECKED &&
     perm_field(perm_q, cp_num) == PERM_NONE) |-> trap);

  // R8
  alt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && alt_mode && !en_pad[cp_num]) |-> trap);

  // R11
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_reserved |-> (trap && !alt_mode));

endmodule

// File: rtl/cp_access_gate.sv
module cp_access_gate
  import cpg_pkg::*;
#(
  parameter int          NUM_CHECKED  = 14,
  parameter int          CP_FIELD_LSB = 8,
  parameter logic [31:0] FP_MASK      = 32'h00F0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fpu_present,
  input  logic        alt_mode,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic        user_mode,
  output logic        trap,
  output logic        trap_reserved
);

  localparam int EN_PAD_W = 32 - NUM_CHECKED;

  logic [31:0]            perm_q;
  logic [NUM_CHECKED-1:0] en_q;
  logic                   perm_wr;
  logic                   en_wr;
  cp_num_t                cp_num;

  assign perm_wr = reg_wr_en & ~reg_sel;
  assign en_wr   = reg_wr_en & reg_sel;

  cpg_perm_reg #(.FP_MASK(FP_MASK)) u_perm (
    .clk(clk), .rst_n(rst_n), .wr_en(perm_wr), .wdata(reg_wdata),
    .fpu_present(fpu_present), .perm_q(perm_q)
  );

  cpg_enable_reg #(.NUM_CHECKED(NUM_CHECKED)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(en_wr),
    .wdata(reg_wdata[NUM_CHECKED-1:0]), .en_q(en_q)
  );

  cpg_decide #(.NUM_CHECKED(NUM_CHECKED), .CP_FIELD_LSB(CP_FIELD_LSB)) u_dec (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .user_mode(user_mode), .alt_mode(alt_mode), .perm_q(perm_q), .en_q(en_q),
    .trap(trap), .trap_reserved(trap_reserved), .cp_num(cp_num)
  );

  assign reg_rdata = reg_sel ? {{EN_PAD_W{1'b0}}, en_q} : perm_q;

  // R2
  high_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cp_num) >= NUM_CHECKED) |-> (!trap && !trap_reserved));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> (!trap && !trap_reserved));

endmodule

// File: tb/cp_access_gate_bench.sv
`timescale 1ns/1ps
module cp_access_gate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fpu_present = 1'b0, alt_mode = 1'b0, reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, insn = '0;
  logic        insn_valid = 1'b0, user_mode = 1'b0;
  logic [31:0] reg_rdata;
  logic        trap, trap_reserved;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cp_access_gate u_cp_access_gate (
    .clk(clk), .rst_n(rst_n), .fpu_present(fpu_present), .alt_mode(alt_mode),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .insn_valid(insn_valid), .insn(insn),
    .user_mode(user_mode), .trap(trap), .trap_reserved(trap_reserved)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #0.5;
  endtask

  function automatic bit exp_trap(bit alt, int cp, bit usr, logic [31:0] p, logic [13:0] en);
    int code;
    if (cp >= 14) return 1'b0;
    if (alt) return !en[cp];
    code = (p >> (2 * cp)) & 3;
    if (code == 0 || code == 2) return 1'b1;
    if (code == 1) return usr;
    return 1'b0;
  endfunction

  function automatic bit exp_rsvd(bit alt, int cp, logic [31:0] p);
    if (alt || cp >= 14) return 1'b0;
    return ((p >> (2 * cp)) & 3) == 2;
  endfunction

  function automatic string tag_of(bit alt, int cp, logic [31:0] p);
    if (cp >= 14) return "R1/R2";
    if (alt) return "R1/R8";
    case ((p >> (2 * cp)) & 3)
      0: return "R1/R3";
      1: return "R1/R4";
      2: return "R1/R5";
      default: return "R1/R6";
    endcase
  endfunction

  // Sweep all coprocessor numbers and both modes for the stored images
  task automatic sweep(input bit alt, input logic [31:0] p, input logic [13:0] en, input int seed);
    for (int cp = 0; cp < 16; cp++) begin
      for (int u = 0; u < 2; u++) begin
        @(negedge clk);
        alt_mode = alt; user_mode = u[0];
        insn = ((32'hC3A5_F0FF ^ (seed << 24) ^ (u << 13)) & ~32'h0000_0F00)
               | (32'(cp) << 8);
        insn_valid = 1'b1;
        #1;
        check(trap == exp_trap(alt, cp, u[0], p, en), tag_of(alt, cp, p),
              32'(trap), 32'(exp_trap(alt, cp, u[0], p, en)));
        check(trap_reserved == exp_rsvd(alt, cp, p), "R11",
              32'(trap_reserved), 32'(exp_rsvd(alt, cp, p)));
        insn_valid = 1'b0;
        #0.5;
        check(!trap && !trap_reserved, "R10", {trap, trap_reserved}, 32'h0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pimg;
    logic [13:0] eimg;
    logic [31:0] en_list [6];
    en_list = '{32'h0, 32'h3FFF, 32'h2AAA, 32'h1555, 32'h0400, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    reg_sel = 1'b0; #0.5;
    check(reg_rdata == 32'h0, "R9", reg_rdata, 32'h0);
    reg_sel = 1'b1; #0.5;
    check(reg_rdata == 32'h0, "R9", reg_rdata, 32'h0);
    sweep(1'b0, 32'h0, 14'h0, 1);

    // R7: no floating-point unit, nothing writable
    fpu_present = 1'b0;
    wr(1'b0, 32'hFFFF_FFFF);
    check(reg_rdata == 32'h0, "R7", reg_rdata, 32'h0);

    // R7 with unit present, all writable-field values
    fpu_present = 1'b1;
    for (int v = 0; v < 16; v++) begin
      pimg = 32'(v) << 20;
      wr(1'b0, 32'hFF0F_FFFF | pimg);
      check(reg_rdata == pimg, "R7", reg_rdata, pimg);
      sweep(1'b0, pimg, 14'h0, v);
    end

    // R8: alternate scheme, permission register open then closed
    for (int k = 0; k < 6; k++) begin
      eimg = en_list[k][13:0];
      wr(1'b1, en_list[k]);
      check(reg_rdata == {18'h0, eimg}, "R8", reg_rdata, {18'h0, eimg});
      pimg = (k % 2 == 0) ? 32'h00F0_0000 : 32'h0;
      wr(1'b0, pimg);
      sweep(1'b1, pimg, eimg, k + 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule